// File: doc/BRIEF.md
# Serial Link Compliance Pattern Generator

This block produces the transmit symbol stream for the transmitter compliance patterns of a multi-gigabit 8b/10b serial link. A 4-bit pattern code picks one pattern from a fixed catalogue. Each pattern serves one jitter measurement: a scrambled idle-like stream exposes data-dependent jitter, a Nyquist-rate clock stream isolates random jitter, a half-rate stream, a comma stream, two K28.7 streams and two long run-length streams cover the rest. Every pattern carries its own scrambling and de-emphasis setting.

The output is one 10-bit symbol per clock with a valid strobe, plus a flag that tells the analog driver whether to apply transmit de-emphasis. The scrambled pattern runs through an internal 16-bit LFSR and a full 8b/10b encoder. The fixed codes keep their own running disparity. The run-length patterns bypass the encoder and pack raw bits. For the low-frequency signalling code the symbol path goes quiet and a request flag is raised, so that an outer block can do the signalling.

The controller is a state machine with six states. ST_RESTART is entered whenever the pattern code changes, and also out of reset. From ST_RESTART the machine moves on one cycle later, according to the held code: to ST_SCRAMBLE (code 0), ST_FIXED (codes 1, 2, 3, 5, 6), ST_LFPS (code 4), ST_RUN (codes 7, 8) or ST_IDLE (codes 9 to 15). Each of those states stays where it is until the code changes, and that change is its only exit, back to ST_RESTART.

Top module: `compliance_pattern_gen`

## Requirements
- R1: While reset is held, and in the first cycle after reset, sym_valid, deemph_en and lfps_req are all 0.
- R2: A pattern code sampled at a clock edge that differs from the code sampled at the previous edge restarts generation. sym_valid and lfps_req are 0 after that edge and after the following edge. The first symbol of the new pattern appears after the third edge. A restart reseeds the scrambler, sets running disparity negative and sets the run-length bit position to zero.
- R3: Code 0 sends the data byte 0x00 scrambled by a Galois LFSR with polynomial x^16+x^5+x^4+x^3+1, seeded 0xFFFF. For each symbol the LFSR takes 8 steps. Step i (i = 0 first) supplies byte bit i from LFSR bit 15. The LFSR then shifts left, and if the bit that left was 1 it XORs 0x0039. The byte is 8b/10b encoded.
- R4: Code 1 sends D10.2 in every cycle, which is the symbol 0101010101. sym is {a,b,c,d,e,i,f,g,h,j} with a at bit 9, and bit 9 is sent first; this layout holds for every code.
- R5: Code 2 sends D24.3, alternating 1100110011 and 0011001100, starting with 1100110011.
- R6: Code 3 sends K28.5, alternating 0011111010 and 1100000101, starting with 0011111010.
- R7: Codes 5 and 6 send K28.7 as 0011111000 in every cycle. deemph_en is 1 with each symbol of code 5 and 0 for code 6.
- R8: Codes 7 and 8 send N one bits followed by N zero bits, repeating, packed 10 bits per symbol with bit 9 first. deemph_en is 1 for code 7 and 0 for code 8.
- R9: A run_len below 50 gives N = 50. A run_len above 250 gives N = 250. Values from 50 to 250 are used as they are.
- R10: N is taken from run_len during the restart cycle. Changes to run_len while a run pattern is playing have no effect on the bit stream.
- R11: Code 4 holds lfps_req at 1 and sym_valid at 0.
- R12: Codes 9 to 15 hold sym_valid, deemph_en and lfps_req at 0.
- R13: For codes 0 to 3, 5 and 6, running disparity is tracked from symbol to symbol. A symbol without exactly five ones flips it, and each code uses the 8b/10b column that matches the current disparity. Every such symbol has four, five or six ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_sel | input | 4 | Compliance pattern code |
| run_len | input | 8 | Requested run length for codes 7 and 8 |
| sym | output | 10 | Transmit symbol, bit 9 sent first |
| sym_valid | output | 1 | Symbol strobe |
| deemph_en | output | 1 | Apply transmit de-emphasis to this symbol |
| lfps_req | output | 1 | Low-frequency signalling requested |

## Verification
The bench uses the default parameters: a 16-bit LFSR, an 8-bit run_len and run limits of 50 and 250. This is small enough to sweep every pattern code from 0 to 15. It also allows 200 scrambled symbols checked against an independent LFSR and encoder model, and more than two full periods of each run pattern, including the 500-bit period at the upper limit. The run-length points sit on both clamp edges, outside them, and at odd values whose period does not divide by ten. That forces the wrap of the bit position to fall inside a symbol.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    localparam int SEL_W  = 4;
    localparam int BYTE_W = 8;
    localparam int SYM_W  = 10;

    localparam logic [SEL_W-1:0] PAT_SCRAM   = 4'd0;
    localparam logic [SEL_W-1:0] PAT_NYQ     = 4'd1;
    localparam logic [SEL_W-1:0] PAT_HALF    = 4'd2;
    localparam logic [SEL_W-1:0] PAT_COMMA   = 4'd3;
    localparam logic [SEL_W-1:0] PAT_LFPS    = 4'd4;
    localparam logic [SEL_W-1:0] PAT_K7_DE   = 4'd5;
    localparam logic [SEL_W-1:0] PAT_K7      = 4'd6;
    localparam logic [SEL_W-1:0] PAT_RUN_DE  = 4'd7;
    localparam logic [SEL_W-1:0] PAT_RUN     = 4'd8;

    // byte values {HGF,EDCBA}
    localparam logic [BYTE_W-1:0] BYTE_D10_2 = 8'h4A;
    localparam logic [BYTE_W-1:0] BYTE_D24_3 = 8'h78;
    localparam logic [BYTE_W-1:0] BYTE_K28_5 = 8'hBC;
    localparam logic [BYTE_W-1:0] BYTE_K28_7 = 8'hFC;

    typedef enum logic [2:0] {
        ST_RESTART,
        ST_SCRAMBLE,
        ST_FIXED,
        ST_RUN,
        ST_LFPS,
        ST_IDLE
    } cpg_state_e;

    function automatic cpg_state_e state_for(input logic [SEL_W-1:0] sel);
        cpg_state_e st;
        case (sel)
            PAT_SCRAM:                                      st = ST_SCRAMBLE;
            PAT_NYQ, PAT_HALF, PAT_COMMA, PAT_K7_DE, PAT_K7: st = ST_FIXED;
            PAT_LFPS:                                       st = ST_LFPS;
            PAT_RUN_DE, PAT_RUN:                            st = ST_RUN;
            default:                                        st = ST_IDLE;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/cpg_scrambler.sv
module cpg_scrambler #(
    parameter int                  LFSR_W = 16,
    parameter logic [LFSR_W-1:0]   SEED   = 16'hFFFF,
    parameter logic [LFSR_W-1:0]   TAPS   = 16'h0039,
    parameter int                  BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [BYTE_W-1:0] byte_o
);

    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_n;

    // walk BYTE_W Galois steps; each leaving MSB scrambles one byte bit
    always_comb begin
        logic [LFSR_W-1:0] walk;
        walk   = lfsr_q;
        byte_o = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            byte_o[i] = walk[LFSR_W-1];
            walk      = {walk[LFSR_W-2:0], 1'b0} ^ (walk[LFSR_W-1] ? TAPS : '0);
        end
        lfsr_n = walk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            lfsr_q <= SEED;
        end else if (step) begin
            lfsr_q <= lfsr_n;
        end
    end

endmodule

// File: rtl/cpg_encoder.sv
module cpg_encoder (
    input  logic [7:0] data,
    input  logic       is_k,
    input  logic       rd_in,
    output logic [9:0] code,
    output logic       rd_out
);

    function automatic logic [5:0] six_neg(input logic [4:0] x);
        logic [5:0] c;
        case (x)
            5'd0:  c = 6'b100111;  5'd1:  c = 6'b011101;
            5'd2:  c = 6'b101101;  5'd3:  c = 6'b110001;
            5'd4:  c = 6'b110101;  5'd5:  c = 6'b101001;
            5'd6:  c = 6'b011001;  5'd7:  c = 6'b111000;
            5'd8:  c = 6'b111001;  5'd9:  c = 6'b100101;
            5'd10: c = 6'b010101;  5'd11: c = 6'b110100;
            5'd12: c = 6'b001101;  5'd13: c = 6'b101100;
            5'd14: c = 6'b011100;  5'd15: c = 6'b010111;
            5'd16: c = 6'b011011;  5'd17: c = 6'b100011;
            5'd18: c = 6'b010011;  5'd19: c = 6'b110010;
            5'd20: c = 6'b001011;  5'd21: c = 6'b101010;
            5'd22: c = 6'b011010;  5'd23: c = 6'b111010;
            5'd24: c = 6'b110011;  5'd25: c = 6'b100110;
            5'd26: c = 6'b010110;  5'd27: c = 6'b110110;
            5'd28: c = 6'b001110;  5'd29: c = 6'b101110;
            5'd30: c = 6'b011110;  default: c = 6'b101011;
        endcase
        return c;
    endfunction

    function automatic logic [3:0] four_neg(input logic [2:0] y);
        logic [3:0] c;
        case (y)
            3'd0: c = 4'b1011;  3'd1: c = 4'b1001;
            3'd2: c = 4'b0101;  3'd3: c = 4'b1100;
            3'd4: c = 4'b1101;  3'd5: c = 4'b1010;
            3'd6: c = 4'b0110;  default: c = 4'b1110;
        endcase
        return c;
    endfunction

    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] c6_base, c6;
    logic [3:0] c4_base, c4;
    logic       bal6, bal4, rd_mid, use_alt;

    assign x = data[4:0];
    assign y = data[7:5];

    always_comb begin
        c6_base = is_k ? 6'b001111 : six_neg(x);
        bal6    = ($countones(c6_base) == 3);
        c6      = (rd_in && (!bal6 || (!is_k && x == 5'd7))) ? ~c6_base : c6_base;
        rd_mid  = bal6 ? rd_in : ~rd_in;

        use_alt = is_k
               || (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20))
               || ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14));
        if (y == 3'd7) begin
            c4_base = use_alt ? 4'b0111 : 4'b1110;
        end else begin
            c4_base = four_neg(y);
        end
        bal4 = ($countones(c4_base) == 2);
        if (!bal4 || y == 3'd3) begin
            c4 = rd_mid ? ~c4_base : c4_base;
        end else if (is_k) begin
            c4 = rd_mid ? c4_base : ~c4_base;
        end else begin
            c4 = c4_base;
        end
    end

    assign code   = {c6, c4};
    assign rd_out = rd_in ^ ($countones({c6, c4}) != 5);

endmodule

// File: rtl/cpg_runlen.sv
module cpg_runlen #(
    parameter int LEN_W   = 8,
    parameter int RUN_MIN = 50,
    parameter int RUN_MAX = 250,
    parameter int SYM_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [LEN_W-1:0] run_len,
    output logic [SYM_W-1:0] bits_o
);

    localparam int N_W   = $clog2(RUN_MAX + 1);
    localparam int POS_W = $clog2(2 * RUN_MAX + SYM_W + 1);

    logic [N_W-1:0]   n_q, n_d;
    logic [POS_W-1:0] pos_q, pos_sum, pos_n, period;

    always_comb begin
        if (int'(run_len) < RUN_MIN) begin
            n_d = N_W'(RUN_MIN);
        end else if (int'(run_len) > RUN_MAX) begin
            n_d = N_W'(RUN_MAX);
        end else begin
            n_d = N_W'(run_len);
        end
    end

    assign period  = POS_W'({n_q, 1'b0});
    assign pos_sum = pos_q + POS_W'(SYM_W);
    assign pos_n   = (pos_sum >= period) ? pos_sum - period : pos_sum;

    for (genvar k = 0; k < SYM_W; k++) begin : g_slot
        logic [POS_W-1:0] raw, wrapped;
        assign raw                = pos_q + POS_W'(k);
        assign wrapped            = (raw >= period) ? raw - period : raw;
        assign bits_o[SYM_W-1-k]  = (wrapped < POS_W'(n_q));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q   <= N_W'(RUN_MIN);
            pos_q <= '0;
        end else if (load) begin
            n_q   <= n_d;
            pos_q <= '0;
        end else if (step) begin
            pos_q <= pos_n;
        end
    end

endmodule

// File: rtl/compliance_pattern_gen.sv
module compliance_pattern_gen
    import cpg_pkg::*;
#(
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hFFFF,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'h0039,
    parameter int                LEN_W     = 8,
    parameter int                RUN_MIN   = 50,
    parameter int                RUN_MAX   = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       pat_sel,
    input  logic [LEN_W-1:0] run_len,
    output logic [9:0]       sym,
    output logic             sym_valid,
    output logic             deemph_en,
    output logic             lfps_req
);

    cpg_state_e         state_q, state_n;
    logic [SEL_W-1:0]   sel_q;
    logic               changed, load, scr_step, run_step, enc_step;
    logic               rd_q, rd_next;
    logic [BYTE_W-1:0]  scr_byte, fix_byte, enc_byte;
    logic               fix_k;
    logic [SYM_W-1:0]   enc_code, run_bits;
    logic               de_sel;

    assign changed  = (pat_sel != sel_q);
    assign load     = (state_q == ST_RESTART);
    assign scr_step = (state_q == ST_SCRAMBLE) && !changed;
    assign run_step = (state_q == ST_RUN) && !changed;
    assign enc_step = (state_q == ST_SCRAMBLE || state_q == ST_FIXED) && !changed;
    assign de_sel   = (sel_q == PAT_K7_DE) || (sel_q == PAT_RUN_DE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RESTART;
            sel_q   <= '0;
        end else begin
            state_q <= state_n;
            sel_q   <= pat_sel;
        end
    end

    always_comb begin
        state_n = state_q;
        if (changed) begin
            state_n = ST_RESTART;
        end else begin
            unique case (state_q)
                ST_RESTART:  state_n = state_for(sel_q);
                ST_SCRAMBLE: state_n = ST_SCRAMBLE;
                ST_FIXED:    state_n = ST_FIXED;
                ST_RUN:      state_n = ST_RUN;
                ST_LFPS:     state_n = ST_LFPS;
                ST_IDLE:     state_n = ST_IDLE;
                default:     state_n = ST_RESTART;
            endcase
        end
    end

    // fixed byte per pattern code
    always_comb begin
        fix_byte = BYTE_D10_2;
        fix_k    = 1'b0;
        case (sel_q)
            PAT_HALF:          fix_byte = BYTE_D24_3;
            PAT_COMMA: begin   fix_byte = BYTE_K28_5; fix_k = 1'b1; end
            PAT_K7_DE, PAT_K7: begin fix_byte = BYTE_K28_7; fix_k = 1'b1; end
            default:           fix_byte = BYTE_D10_2;
        endcase
    end

    assign enc_byte = (state_q == ST_SCRAMBLE) ? scr_byte : fix_byte;

    cpg_scrambler #(
        .LFSR_W (LFSR_W),
        .SEED   (LFSR_SEED),
        .TAPS   (LFSR_TAPS),
        .BYTE_W (BYTE_W)
    ) i_scrambler (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (scr_step),
        .byte_o (scr_byte)
    );

    cpg_encoder i_encoder (
        .data   (enc_byte),
        .is_k   (fix_k && state_q == ST_FIXED),
        .rd_in  (rd_q),
        .code   (enc_code),
        .rd_out (rd_next)
    );

    cpg_runlen #(
        .LEN_W   (LEN_W),
        .RUN_MIN (RUN_MIN),
        .RUN_MAX (RUN_MAX),
        .SYM_W   (SYM_W)
    ) i_runlen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (run_step),
        .run_len (run_len),
        .bits_o  (run_bits)
    );

    // running disparity, 0 = negative
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rd_q <= 1'b0;
        end else if (enc_step) begin
            rd_q <= rd_next;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym       <= '0;
            sym_valid <= 1'b0;
            deemph_en <= 1'b0;
            lfps_req  <= 1'b0;
        end else begin
            sym       <= '0;
            sym_valid <= 1'b0;
            deemph_en <= 1'b0;
            lfps_req  <= 1'b0;
            if (!changed) begin
                unique case (state_q)
                    ST_SCRAMBLE, ST_FIXED: begin
                        sym       <= enc_code;
                        sym_valid <= 1'b1;
                        deemph_en <= de_sel;
                    end
                    ST_RUN: begin
                        sym       <= run_bits;
                        sym_valid <= 1'b1;
                        deemph_en <= de_sel;
                    end
                    ST_LFPS:    lfps_req <= 1'b1;
                    ST_RESTART: sym_valid <= 1'b0;
                    ST_IDLE:    sym_valid <= 1'b0;
                    default:    sym_valid <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/cpg_checker.sv
module cpg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] pat_sel,
    input logic [9:0] sym,
    input logic       sym_valid,
    input logic       deemph_en,
    input logic       lfps_req
);

    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_QUIET_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && pat_sel != $past(pat_sel)) |=> (!sym_valid && !lfps_req)); // R2

    AST_LFPS_NO_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
        lfps_req |-> !sym_valid); // R11

    AST_DEEMPH_WITH_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
        deemph_en |-> sym_valid); // R7

    AST_CODE_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && sym_valid && $past(pat_sel) <= 4'd6)
        |-> ($countones(sym) >= 4 && $countones(sym) <= 6)); // R13

    AST_NYQUIST_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && sym_valid && $past(pat_sel) == 4'd1)
        |-> (sym == 10'b0101010101)); // R4

    AST_COMMA_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && sym_valid && $past(sym_valid)
         && $past(pat_sel) == 4'd3 && $past(pat_sel, 2) == 4'd3)
        |-> (sym != $past(sym))); // R6

endmodule

bind compliance_pattern_gen cpg_checker i_cpg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pat_sel   (pat_sel),
    .sym       (sym),
    .sym_valid (sym_valid),
    .deemph_en (deemph_en),
    .lfps_req  (lfps_req)
);

// File: tb/test_compliance_pattern_gen.sv
module test_compliance_pattern_gen;

    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] T6 [32] = '{
        6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
        6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
        6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
        6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
        6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
        6'b011110, 6'b101011};
    localparam logic [3:0] T4 [8] = '{
        4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pat_sel = 4'd9;
    logic [7:0] run_len = 8'd50;
    logic [9:0] sym;
    logic       sym_valid, deemph_en, lfps_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    compliance_pattern_gen i_compliance_pattern_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .pat_sel   (pat_sel),
        .run_len   (run_len),
        .sym       (sym),
        .sym_valid (sym_valid),
        .deemph_en (deemph_en),
        .lfps_req  (lfps_req)
    );

    task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [10:0] enc_ref(input logic [7:0] b, input bit k, input bit rd);
        logic [4:0] x;
        logic [2:0] y;
        logic [5:0] s6;
        logic [3:0] s4;
        bit         rm;
        x  = b[4:0];
        y  = b[7:5];
        s6 = k ? 6'b001111 : T6[x];
        if (rd && ($countones(s6) != 3 || (!k && x == 5'd7))) s6 = ~s6;
        rm = ($countones(s6) == 3) ? rd : !rd;
        if (y == 3'd7) begin
            if (k || (!rm && (x == 17 || x == 18 || x == 20)) || (rm && (x == 11 || x == 13 || x == 14)))
                s4 = 4'b0111;
            else
                s4 = 4'b1110;
        end else begin
            s4 = T4[y];
        end
        if ($countones(s4) != 2 || y == 3'd3) begin
            if (rm) s4 = ~s4;
        end else if (k && !rm) begin
            s4 = ~s4;
        end
        return {rd ^ ($countones({s6, s4}) != 5), s6, s4};
    endfunction

    // select a code and check the R2 restart window; returns on the first symbol
    task automatic pick(input logic [3:0] s, input logic [7:0] n);
        pat_sel = s;
        run_len = n;
        @(negedge clk);
        chk(!sym_valid && !lfps_req, "R2 quiet edge1", {8'd0, sym_valid, lfps_req}, 10'd0);
        @(negedge clk);
        chk(!sym_valid && !lfps_req, "R2 quiet edge2", {8'd0, sym_valid, lfps_req}, 10'd0);
        @(negedge clk);
    endtask

    task automatic run_encoded(input logic [3:0] s, input int count, input string req);
        logic [15:0] lf;
        bit          rd;
        logic [7:0]  b;
        bit          k;
        logic [10:0] r;
        lf = 16'hFFFF;
        rd = 1'b0;
        k  = 1'b0;
        b  = 8'h00;
        case (s)
            4'd1: b = 8'h4A;
            4'd2: b = 8'h78;
            4'd3: begin b = 8'hBC; k = 1'b1; end
            4'd5, 4'd6: begin b = 8'hFC; k = 1'b1; end
            default: b = 8'h00;
        endcase
        pick(s, 8'd50);
        for (int i = 0; i < count; i++) begin
            if (s == 4'd0) begin
                for (int j = 0; j < 8; j++) begin
                    b[j] = lf[15];
                    lf   = {lf[14:0], 1'b0} ^ (lf[15] ? 16'h0039 : 16'h0000);
                end
            end
            r = enc_ref(b, k, rd);
            chk(sym_valid && sym == r[9:0], req, sym, r[9:0]);
            chk(deemph_en == (s == 4'd5), {req, " deemph"}, {9'd0, deemph_en}, {9'd0, s == 4'd5});
            chk($countones(sym) >= 4 && $countones(sym) <= 6, "R13 weight", sym, r[9:0]);
            rd = r[10];
            @(negedge clk);
        end
    endtask

    // run patterns: n_eff is the clamped length the bench expects
    task automatic run_bits(input logic [3:0] s, input logic [7:0] n, input int n_eff,
                            input int count, input string req);
        int         g;
        logic [9:0] e;
        pick(s, n);
        g = 0;
        for (int i = 0; i < count; i++) begin
            for (int kk = 0; kk < 10; kk++) e[9 - kk] = (((g + kk) % (2 * n_eff)) < n_eff);
            chk(sym_valid && sym == e, req, sym, e);
            chk(deemph_en == (s == 4'd7), "R8 deemph", {9'd0, deemph_en}, {9'd0, s == 4'd7});
            g += 10;
            if (i == count / 2 && req == "R10 held") run_len = 8'd200;
            @(negedge clk);
        end
    endtask

    task automatic run_quiet(input logic [3:0] s, input int count);
        pick(s, 8'd50);
        for (int i = 0; i < count; i++) begin
            if (s == 4'd4)
                chk(lfps_req && !sym_valid, "R11 lfps", {8'd0, lfps_req, sym_valid}, 10'b10);
            else
                chk(!lfps_req && !sym_valid && !deemph_en, "R12 unused code",
                    {7'd0, lfps_req, sym_valid, deemph_en}, 10'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!sym_valid && !deemph_en && !lfps_req, "R1 reset", {7'd0, sym_valid, deemph_en, lfps_req}, 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sym_valid && !deemph_en && !lfps_req, "R1 after reset", {7'd0, sym_valid, deemph_en, lfps_req}, 10'd0);

        run_encoded(4'd0, 200, "R3 scrambled");
        run_encoded(4'd1, 20, "R4 nyquist");
        run_encoded(4'd2, 20, "R5 half rate");
        run_encoded(4'd3, 20, "R6 comma");
        run_encoded(4'd5, 20, "R7 k28.7 de");
        run_encoded(4'd6, 20, "R7 k28.7");
        run_encoded(4'd0, 30, "R3 reseed");
        run_quiet(4'd4, 8);
        for (int c = 9; c < 16; c++) run_quiet(4'(c), 5);

        run_bits(4'd7, 8'd50, 50, 25, "R8 run50");
        run_bits(4'd8, 8'd97, 97, 45, "R8 run97");
        run_bits(4'd7, 8'd123, 123, 55, "R8 run123");
        run_bits(4'd8, 8'd250, 250, 110, "R9 run250");
        run_bits(4'd7, 8'd40, 50, 25, "R9 clamp low");
        run_bits(4'd8, 8'd0, 50, 25, "R9 clamp zero");
        run_bits(4'd7, 8'd255, 250, 110, "R9 clamp high");
        run_bits(4'd8, 8'd51, 51, 25, "R9 run51");
        run_bits(4'd7, 8'd60, 60, 60, "R10 held");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule